// File: doc/BRIEF.md
# Constant-Divisor Reciprocal Divider

This block divides an unsigned input word by a divisor fixed at elaboration time, producing both the floor quotient and the remainder in a single combinational path. It multiplies the input by a scaled reciprocal of the divisor and adds that same multiplier once. The sum is then shifted right, so the quotient is `(MULT*X + MULT) >> SHIFT`. The remainder is rebuilt by multiplying the quotient back by the divisor and subtracting the result from the input.

Both constants come from an elaboration-time function. `MULT` is `floor(2^SHIFT / DIVISOR)`. `SHIFT` is the smallest value not below `WIDTH` for which the quotient is exact for every input. The function finds it by examining, for each residue class, the largest input in that class. The block suits address arithmetic such as splitting a flat index into rows and columns, or packing words into memories whose width is not a power of two. It sits in a datapath with no clock or handshake of its own.

Top module: `divc_recip`

## Requirements
- R1: For every `WIDTH`-bit unsigned input X, `quo_out` equals floor(X / DIVISOR).
- R2: For every input, `rem_out` equals X mod DIVISOR, and so is always below DIVISOR.
- R3: `rem_out` is RW bits wide and `quo_out` is WIDTH − RW + 1 bits wide, where RW is the bit width of DIVISOR − 1.
- R4: An input of zero gives a quotient of 0 and a remainder of 0.
- R5: At the first step boundary, X = DIVISOR − 1 gives quotient 0 and remainder DIVISOR − 1, and X = DIVISOR gives quotient 1 and remainder 0.
- R6: The all-ones input gives the largest quotient, floor((2^WIDTH − 1) / DIVISOR), which fits in `quo_out` with no loss of high bits.
- R7: For every input, DIVISOR × `quo_out` + `rem_out` equals X, and the back-multiplied product never exceeds X.
- R8: The outputs depend on the current input alone. A new input is reflected at the outputs with no clock edge in between.
- R9: DIVISOR must be at least 3, must not be a power of two, and must not exceed 2^WIDTH.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_in | input | WIDTH | Unsigned dividend |
| quo_out | output | WIDTH − $clog2(DIVISOR) + 1 | Floor quotient |
| rem_out | output | $clog2(DIVISOR) | Remainder |

## Verification
At the default width the bench applies every possible dividend. This separates a correct shift from one that is a bit too short: an error of that kind shows only near the top of the range, where the reciprocal's truncation error builds up. The corner inputs are tried one at a time. Zero and DIVISOR − 1 versus DIVISOR catch an addend that is missing or off by one, because those are the inputs where the quotient steps. The all-ones input catches a quotient that has been cut to too few bits. Every result is also checked against the identity DIVISOR × Q + R = X, and this check would flag an error in the back-multiply or the subtraction even if the quotient check were weak.

// File: rtl/divc_pkg.sv
// divc_pkg: elaboration-time constant selection for the reciprocal divider.
// Assumes divisor >= 3, not a power of two, and width + 40 < CW.
package divc_pkg;

    localparam int CW = 160;
    typedef logic [CW-1:0] cword_t;

    // Smallest shift >= width for which floor(mult*(X+1) / 2^shift)
    // is exact for all width-bit X; checked on the largest X of each residue.
    function automatic int calc_shift(input int d, input int n);
        cword_t p, a, e, top, xs, dw, sw;
        int     res;
        bit     ok;
        dw  = cword_t'(d);
        top = (cword_t'(1) << n) - cword_t'(1);
        res = n + 40;
        for (int m = n + 40; m >= n; m--) begin
            p  = cword_t'(1) << m;
            a  = p / dw;
            e  = p - a * dw;
            ok = (e != '0);
            for (int s = 0; s < d; s++) begin
                sw = cword_t'(s);
                if (sw <= top) begin
                    xs = top - ((top - sw) % dw);
                    if (e * (xs + cword_t'(1)) > (sw + cword_t'(1)) * p)
                        ok = 1'b0;
                end
            end
            if (ok)
                res = m;
        end
        return res;
    endfunction

    // Scaled reciprocal floor(2^shift / d).
    function automatic cword_t calc_mult(input int d, input int m);
        return (cword_t'(1) << m) / cword_t'(d);
    endfunction

endpackage

// File: rtl/divc_muladd.sv
// divc_muladd: forms MULT*X + MULT in a word wide enough that it cannot
// overflow, then shifts right by SHIFT to give the floor quotient.
// Assumes MULT and SHIFT come from divc_pkg for the same divisor and width.
module divc_muladd #(
    parameter int WIDTH = 16,
    parameter int MUL_W = 17,
    parameter int SHIFT = 17,
    parameter int Q_W   = 15,
    parameter logic [MUL_W-1:0] MULT = '1
) (
    input  logic [WIDTH-1:0] x_in,
    output logic [Q_W-1:0]   quo
);
    localparam int P_W = WIDTH + SHIFT + 1;

    logic [P_W-1:0] acc;
    logic [P_W-1:0] shifted;

    // Multiply-add with equal multiplier and addend, then drop SHIFT bits.
    always_comb begin
        acc     = P_W'(MULT) * P_W'(x_in) + P_W'(MULT);
        shifted = acc >> SHIFT;
        quo     = shifted[Q_W-1:0];
    end

    // R6: the shifted sum must fit the quotient width.
    always_comb begin
        if (!$isunknown(x_in))
            p_quo_fits_r6: assert ((shifted >> Q_W) == '0)
                else $error("quotient overflow for x=%0d", x_in);
    end

endmodule

// File: rtl/divc_backmul.sv
// divc_backmul: multiplies the quotient back by the fixed divisor.
// Assumes the quotient is at most floor((2^WIDTH-1)/DIVISOR).
module divc_backmul #(
    parameter int WIDTH   = 16,
    parameter int Q_W     = 15,
    parameter int DIVISOR = 3
) (
    input  logic [Q_W-1:0]   quo,
    output logic [WIDTH:0]   prod
);
    localparam int PW = WIDTH + 1;

    // Constant multiply, one bit wider than the dividend to expose overshoot.
    always_comb begin
        prod = PW'(DIVISOR) * PW'(quo);
    end

    // R7: the back product never leaves the dividend range.
    always_comb begin
        if (!$isunknown(quo))
            p_prod_fits_r7: assert (prod[WIDTH] == 1'b0)
                else $error("back product overflow for q=%0d", quo);
    end

endmodule

// File: rtl/divc_remsub.sv
// divc_remsub: subtracts the back product from the dividend and keeps the
// low bits as the remainder. Assumes prod comes from a floor quotient.
module divc_remsub #(
    parameter int WIDTH   = 16,
    parameter int R_W     = 2,
    parameter int DIVISOR = 3
) (
    input  logic [WIDTH-1:0] x_in,
    input  logic [WIDTH:0]   prod,
    output logic [R_W-1:0]   rem
);
    localparam int PW = WIDTH + 1;

    logic [WIDTH:0] diff;

    // Remainder recovery by subtraction; only the low bits are meaningful.
    always_comb begin
        diff = {1'b0, x_in} - prod;
        rem  = diff[R_W-1:0];
    end

    // R7: quotient too large shows up as a borrow.
    // R2: quotient too small shows up as a difference at or above the divisor.
    always_comb begin
        if (!$isunknown(x_in) && !$isunknown(prod)) begin
            p_no_underflow_r7: assert (diff[WIDTH] == 1'b0)
                else $error("negative remainder for x=%0d", x_in);
            p_rem_below_div_r2: assert (diff < PW'(DIVISOR))
                else $error("remainder %0d not below divisor", diff);
        end
    end

endmodule

// File: rtl/divc_recip.sv
// divc_recip: combinational unsigned divide by a fixed constant, giving the
// floor quotient and the remainder. Assumes DIVISOR >= 3, not a power of
// two, DIVISOR <= 2^WIDTH. No clock: the outputs follow x_in directly.
module divc_recip
    import divc_pkg::*;
#(
    parameter int DIVISOR = 3,
    parameter int WIDTH   = 16
) (
    input  logic [WIDTH-1:0]                     x_in,
    output logic [WIDTH-$clog2(DIVISOR):0]       quo_out,
    output logic [$clog2(DIVISOR)-1:0]           rem_out
);
    localparam int     R_W       = $clog2(DIVISOR);
    localparam int     Q_W       = WIDTH - R_W + 1;
    localparam int     MUL_W     = WIDTH + 1;
    localparam int     SHIFT     = calc_shift(DIVISOR, WIDTH);
    localparam cword_t MULT_FULL = calc_mult(DIVISOR, SHIFT);
    localparam logic [MUL_W-1:0] MULT = MULT_FULL[MUL_W-1:0];

    logic [Q_W-1:0] quo;
    logic [WIDTH:0] prod;
    logic [R_W-1:0] rem;

    divc_muladd #(
        .WIDTH (WIDTH),
        .MUL_W (MUL_W),
        .SHIFT (SHIFT),
        .Q_W   (Q_W),
        .MULT  (MULT)
    ) u_muladd (
        .x_in (x_in),
        .quo  (quo)
    );

    divc_backmul #(
        .WIDTH   (WIDTH),
        .Q_W     (Q_W),
        .DIVISOR (DIVISOR)
    ) u_backmul (
        .quo  (quo),
        .prod (prod)
    );

    divc_remsub #(
        .WIDTH   (WIDTH),
        .R_W     (R_W),
        .DIVISOR (DIVISOR)
    ) u_remsub (
        .x_in (x_in),
        .prod (prod),
        .rem  (rem)
    );

    // Drive the ports from the quotient and remainder stages.
    always_comb begin
        quo_out = quo;
        rem_out = rem;
    end

    // R9: reject a divisor the constant search cannot serve.
    initial begin
        p_divisor_ok_r9: assert (DIVISOR >= 3 && (DIVISOR & (DIVISOR - 1)) != 0)
            else $error("divisor %0d unsupported", DIVISOR);
    end

endmodule

// File: tb/divc_recip_test.sv
// Scoreboard bench: the driver pushes expected results, the monitor pops
// and compares them half a cycle after each input is applied.
module divc_recip_test;
    localparam int DIVISOR = 3;
    localparam int WIDTH   = 16;
    localparam int R_W     = $clog2(DIVISOR);
    localparam int Q_W     = WIDTH - R_W + 1;

    typedef struct {
        logic [WIDTH-1:0] x;
        logic [Q_W-1:0]   q;
        logic [R_W-1:0]   r;
        string            tag;
    } item_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [WIDTH-1:0] x = '0;
    logic [Q_W-1:0]   q;
    logic [R_W-1:0]   r;
    item_t            sbq[$];
    int               checks = 0;
    int               errors = 0;
    bit               done = 1'b0;

    divc_recip #(.DIVISOR(DIVISOR), .WIDTH(WIDTH)) uut (
        .x_in    (x),
        .quo_out (q),
        .rem_out (r)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic drive(input logic [WIDTH-1:0] v, input string tag);
        item_t it;
        @(posedge clk);
        #1;
        x      = v;
        it.x   = v;
        it.q   = Q_W'(longint'(v) / DIVISOR);
        it.r   = R_W'(longint'(v) % DIVISOR);
        it.tag = tag;
        sbq.push_back(it);
    endtask

    // Monitor: compare quotient, remainder and the division identity.
    always @(negedge clk) begin
        if (rst_n && sbq.size() > 0) begin
            item_t it;
            it = sbq.pop_front();
            check(it.tag, longint'(q), longint'(it.q));
            check("R2", longint'(r), longint'(it.r));
            check("R7", longint'(DIVISOR) * longint'(q) + longint'(r), longint'(it.x));
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog actual %0d expected %0d", 200000, checks);
        finish_run();
    end

    initial begin
        // Reset state with a zero input (R4) and port widths (R3).
        repeat (3) @(posedge clk);
        #2;
        check("R4", longint'(q), 0);
        check("R4", longint'(r), 0);
        check("R3", $bits(uut.quo_out), Q_W);
        check("R3", $bits(uut.rem_out), R_W);
        // R8: output follows input without a clock edge.
        x = WIDTH'(DIVISOR);
        #1;
        check("R8", longint'(q), 1);
        x = WIDTH'(DIVISOR - 1);
        #1;
        check("R8", longint'(r), DIVISOR - 1);
        @(posedge clk);
        rst_n = 1'b1;

        drive('0, "R4");
        drive(WIDTH'(DIVISOR - 1), "R5");
        drive(WIDTH'(DIVISOR), "R5");
        drive(WIDTH'(2 * DIVISOR - 1), "R5");
        drive('1, "R6");
        if (WIDTH <= 16) begin
            for (int i = 0; i < (1 << WIDTH); i++)
                drive(WIDTH'(i), "R1");
        end else begin
            for (int i = 0; i < 20000; i++)
                drive(WIDTH'({$urandom, $urandom, $urandom, $urandom}), "R1");
        end
        while (sbq.size() > 0) @(posedge clk);
        @(posedge clk);
        finish_run();
    end

endmodule